// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus that a slave device keeps occupied after a transfer was cut short, typically by holding the data line low while it waits for clock edges that never came. A start request begins a recovery run. The run first asserts a one-cycle pulse that clears the controller's sticky write-1-to-clear status flags. These are stop-complete, interrupt-active, lost-arbitration, incomplete-transfer and transfer-aborted. For the whole run the block holds the byte-transfer engine in soft reset. It leaves both lines released and waits for the synchronized line levels to settle, then samples them.

When both SDA and SCL read high, the bus is free. The run ends with success and issues no clock pulse. Otherwise the block gives SCL one toggle per iteration: it pulls SCL low for a programmable half period, releases it for the same time, and samples again. It stops as soon as the bus reads free. If the bus is still not free after the iteration limit, it ends with a timeout.

A second request, the stop request, ends an aborted combined transfer. It pulls both lines low for one half period and then releases them in the same cycle, which forms a stop condition. Soft reset is held while this happens. The line outputs are open-drain enables: a 1 pulls the line low and a 0 releases it.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, eng_srst_o, clr_flags_o, done_o, success_o and timeout_o are all 0.
- R2: A start accepted in idle makes clr_flags_o 1 for exactly one cycle per run. eng_srst_o is 1 from that cycle through the cycle where done_o is 1, and 0 in the cycle after.
- R3: If the synchronized SDA and SCL both read 1 at the first sample, the run ends with success_o=1 and timeout_o=0. No SCL low pulse is issued.
- R4: During a recovery run sda_oe_o stays 0. Each SCL toggle holds scl_oe_o at 1 for exactly HALF_CYC cycles, followed by at least HALF_CYC cycles at 0 before the next sample.
- R5: When a slave releases SDA after K SCL rising edges, with 1 <= K <= MAX_ITER, the run issues exactly K low pulses and ends with success_o=1.
- R6: Never more than MAX_ITER low pulses are issued per run. If the bus is still not free after MAX_ITER toggles, the run ends with timeout_o=1 and success_o=0. The two flags are never 1 together.
- R7: A bus that becomes free on the last allowed toggle (K = MAX_ITER) ends with success_o=1 and timeout_o=0, because the free check is made before the limit check.
- R8: A stop request in idle raises eng_srst_o and holds scl_oe_o and sda_oe_o both at 1 for exactly HALF_CYC cycles. The block then drops both to 0 in the same cycle and ends with success_o=1. clr_flags_o stays 0 throughout.
- R9: start_i and stop_i have no effect while a run is in progress. clr_flags_o is not pulsed again, and the pulse count of the run does not change.
- R10: done_o is 1 for exactly one cycle at the end of each run. success_o and timeout_o keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a recovery run (idle only) |
| stop_i | input | 1 | Begin a synthesized stop sequence (idle only) |
| scl_i | input | 1 | Sensed SCL line level, asynchronous |
| sda_i | input | 1 | Sensed SDA line level, asynchronous |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| eng_srst_o | output | 1 | Soft reset to the transfer engine |
| clr_flags_o | output | 1 | One-cycle write-1-to-clear pulse for the sticky status flags |
| done_o | output | 1 | One-cycle end-of-run pulse |
| success_o | output | 1 | Last run ended with the bus free or the stop issued |
| timeout_o | output | 1 | Last run reached the iteration limit with the bus still not free |

## Verification
The bench builds the block with HALF_CYC=4, MAX_ITER=6 and SETTLE_CYC=3. With these values a toggle takes eight cycles, so the iteration limit is reached within a few hundred cycles. The default values would need about two hundred thousand cycles for one timed-out run. The small limit lets the bench drive the slave model at K=0, at values inside the limit, at exactly the limit and one beyond it, and with SCL held low. HALF_CYC=4 still leaves room for the two-flop synchronizer to settle before each sample.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SETTLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_FINISH
  } seq_state_t;

  // Bus is free only when both sampled levels are high.
  function automatic logic line_pair_free(input logic sda_lvl, input logic scl_lvl);
    return sda_lvl & scl_lvl;
  endfunction

  // Iteration budget is spent once the toggle count reaches the limit.
  function automatic logic budget_spent(input int unsigned done_cnt, input int unsigned limit);
    return done_cnt >= limit;
  endfunction

  // Timer load value that yields a phase of the given length in cycles.
  function automatic int unsigned phase_load(input int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stable_q;
    // Lines idle high, so both stages reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b1;
        stable_q <= 1'b1;
      end else begin
        meta_q   <= async_i[b];
        stable_q <= meta_q;
      end
    end
    assign sync_o[b] = stable_q;
  end
endmodule

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_unstick_iter.sv
module i2c_unstick_iter #(
  parameter int MAX_ITER = 100,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  output logic          spent_o,
  output logic [IW-1:0] count_o
);
  import i2c_unstick_pkg::*;

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (step_i && !spent_o)       cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = budget_spent(int'(cnt_q), MAX_ITER);
  assign count_o = cnt_q;

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_ITER); // R6
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
  parameter int HALF_CYC   = 1000,
  parameter int MAX_ITER   = 100,
  parameter int SETTLE_CYC = 3,
  localparam int TMAX = (HALF_CYC > SETTLE_CYC) ? HALF_CYC : SETTLE_CYC,
  localparam int TW   = $clog2(TMAX + 1),
  localparam int IW   = $clog2(MAX_ITER + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic eng_srst_o,
  output logic clr_flags_o,
  output logic done_o,
  output logic success_o,
  output logic timeout_o
);
  import i2c_unstick_pkg::*;

  seq_state_t state_q, state_d;

  // Named internal events
  logic [1:0]    line_sync;
  logic          sda_s, scl_s;
  logic          bus_free;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_value;
  logic          iter_clear, iter_step, iter_spent;
  logic [IW-1:0] iter_count;
  logic          ev_accept_rec, ev_accept_stop, ev_ok, ev_to;
  logic          ok_q, to_q;

  i2c_unstick_sync #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_sync)
  );
  assign sda_s    = line_sync[0];
  assign scl_s    = line_sync[1];
  assign bus_free = line_pair_free(sda_s, scl_s);

  i2c_unstick_timer #(.WIDTH(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tmr_load),
    .value_i (tmr_value),
    .zero_o  (tmr_zero)
  );

  i2c_unstick_iter #(.MAX_ITER(MAX_ITER)) u_iter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (iter_clear),
    .step_i  (iter_step),
    .spent_o (iter_spent),
    .count_o (iter_count)
  );

  always_comb begin
    state_d        = state_q;
    tmr_load       = 1'b0;
    tmr_value      = '0;
    iter_clear     = 1'b0;
    iter_step      = 1'b0;
    ev_accept_rec  = 1'b0;
    ev_accept_stop = 1'b0;
    ev_ok          = 1'b0;
    ev_to          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ev_accept_rec = 1'b1;
          state_d       = ST_CLEAR;
        end else if (stop_i) begin
          ev_accept_stop = 1'b1;
          tmr_load       = 1'b1;
          tmr_value      = TW'(phase_load(HALF_CYC));
          state_d        = ST_STOP_LOW;
        end
      end
      ST_CLEAR: begin
        iter_clear = 1'b1;
        tmr_load   = 1'b1;
        tmr_value  = TW'(phase_load(SETTLE_CYC));
        state_d    = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_zero) state_d = ST_CHECK;
      ST_CHECK: begin
        if (bus_free) begin
          ev_ok   = 1'b1;
          state_d = ST_FINISH;
        end else if (iter_spent) begin
          ev_to   = 1'b1;
          state_d = ST_FINISH;
        end else begin
          tmr_load  = 1'b1;
          tmr_value = TW'(phase_load(HALF_CYC));
          state_d   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          tmr_load  = 1'b1;
          tmr_value = TW'(phase_load(HALF_CYC));
          state_d   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          iter_step = 1'b1;
          state_d   = ST_CHECK;
        end
      end
      ST_STOP_LOW: begin
        if (tmr_zero) begin
          ev_ok   = 1'b1;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept_rec || ev_accept_stop) begin
        ok_q <= 1'b0;
        to_q <= 1'b0;
      end else begin
        if (ev_ok) ok_q <= 1'b1;
        if (ev_to) to_q <= 1'b1;
      end
    end
  end

  assign scl_oe_o    = (state_q == ST_LOW) || (state_q == ST_STOP_LOW);
  assign sda_oe_o    = (state_q == ST_STOP_LOW);
  assign eng_srst_o  = (state_q != ST_IDLE);
  assign clr_flags_o = (state_q == ST_CLEAR);
  assign done_o      = (state_q == ST_FINISH);
  assign success_o   = ok_q;
  assign timeout_o   = to_q;

  // Checker state: length of the current SCL pull-low run.
  logic [TW:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run_q <= '0;
    else if (!scl_oe_o)      low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags_o |=> !clr_flags_o); // R2
  AST_SRST_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> eng_srst_o); // R2
  AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(scl_oe_o)) |-> (int'(low_run_q) == HALF_CYC)); // R4
  AST_NO_SDA_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_o && !(state_q == ST_STOP_LOW)) |-> !sda_oe_o); // R4
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(success_o && timeout_o)); // R6
  AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (int'(iter_count) == MAX_ITER)); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $fell(scl_oe_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_srst_o && !start_i && !stop_i) |=> ($stable(success_o) && $stable(timeout_o))); // R10
endmodule

// File: tb/tb_i2c_unstick_seq.sv
module tb_i2c_unstick_seq;
  localparam int HALF = 4;
  localparam int MAXI = 6;
  localparam int SETL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic scl_oe, sda_oe, srst, clr, done, ok, to;
  logic scl_line, sda_line;

  int   hold_k = 0;      // SCL rises before slave releases SDA
  int   rises  = 0;
  bit   scl_stuck = 1'b0;
  bit   prev_scl = 1'b1;

  always #5 clk = ~clk;

  assign scl_line = !scl_oe && !scl_stuck;
  assign sda_line = !sda_oe && !(rises < hold_k);

  i2c_unstick_seq #(.HALF_CYC(HALF), .MAX_ITER(MAXI), .SETTLE_CYC(SETL)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .eng_srst_o(srst),
    .clr_flags_o(clr), .done_o(done), .success_o(ok), .timeout_o(to)
  );

  typedef struct { bit ok; bit to; int pulses; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  int pulses = 0, low_run = 0, clr_cnt = 0, sda_low_run = 0;
  bit in_stop = 1'b0, sda_in_rec = 1'b0, done_seen = 1'b0;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Slave model: counts SCL rising edges on the line.
  always @(negedge clk) begin
    if (scl_line && !prev_scl) rises <= rises + 1;
    prev_scl <= scl_line;
  end

  // Monitor: measures pulses and compares results at done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (clr) clr_cnt++;
      if (!in_stop && sda_oe) sda_in_rec = 1'b1;
      if (scl_oe) low_run++;
      else if (low_run != 0) begin
        if (!in_stop) begin
          check("R4 low phase length", low_run, HALF);
          pulses++;
        end
        low_run = 0;
      end
      if (sda_oe) sda_low_run++;
      if (done) begin
        exp_t e;
        done_seen = 1'b1;
        if (exp_q.size() == 0) check("R10 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check("R3/R5/R6/R7 success flag", ok, e.ok);
          check("R6 timeout flag", to, e.to);
          if (!in_stop) check("R5/R6 pulse count", pulses, e.pulses);
          check("R2 soft reset held at done", srst, 1);
        end
      end
    end
  end

  task automatic wait_done();
    while (!done_seen) @(negedge clk);
    done_seen = 1'b0;
  endtask

  task automatic run_recover(input int k, input bit stuck, input bit e_ok,
                             input bit e_to, input int e_p, input string tag);
    exp_t e;
    @(negedge clk);
    hold_k = k; rises = 0; scl_stuck = stuck;
    pulses = 0; clr_cnt = 0; sda_in_rec = 1'b0; in_stop = 1'b0;
    e.ok = e_ok; e.to = e_to; e.pulses = e_p;
    exp_q.push_back(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R2 soft reset asserted"}, srst, 1);
    // R9: further requests mid-run are ignored
    repeat (3) @(negedge clk);
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    wait_done();
    @(negedge clk);
    check({tag, " R2 soft reset released after done"}, srst, 0);
    check({tag, " R10 done single cycle"}, done, 0);
    check({tag, " R2/R9 clear pulse count"}, clr_cnt, 1);
    check({tag, " R4 SDA never driven"}, sda_in_rec, 0);
    repeat (4) @(negedge clk);
    check({tag, " R10 success held"}, ok, e_ok);
    check({tag, " R10 timeout held"}, to, e_to);
    scl_stuck = 1'b0; hold_k = 0;
    repeat (4) @(negedge clk);
  endtask

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl_oe reset", scl_oe, 0);
    check("R1 sda_oe reset", sda_oe, 0);
    check("R1 srst reset", srst, 0);
    check("R1 clr reset", clr, 0);
    check("R1 done reset", done, 0);
    check("R1 flags reset", {ok, to}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_recover(0,        1'b0, 1'b1, 1'b0, 0,    "free");          // R3
    run_recover(1,        1'b0, 1'b1, 1'b0, 1,    "k1");            // R5
    run_recover(3,        1'b0, 1'b1, 1'b0, 3,    "k3");            // R5
    run_recover(MAXI,     1'b0, 1'b1, 1'b0, MAXI, "klimit");        // R7
    run_recover(MAXI + 1, 1'b0, 1'b0, 1'b1, MAXI, "kover");         // R6
    run_recover(0,        1'b1, 1'b0, 1'b1, MAXI, "sclstuck");      // R6

    // R8: synthesized stop
    begin
      exp_t e;
      @(negedge clk);
      in_stop = 1'b1; clr_cnt = 0; sda_low_run = 0;
      e.ok = 1'b1; e.to = 1'b0; e.pulses = 0;
      exp_q.push_back(e);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check("R8 srst during stop", srst, 1);
      check("R8 scl pulled", scl_oe, 1);
      check("R8 sda pulled", sda_oe, 1);
      while (scl_oe && sda_oe) @(negedge clk);
      check("R8 released together scl", scl_oe, 0);
      check("R8 released together sda", sda_oe, 0);
      check("R8 stop low length", sda_low_run, HALF);
      wait_done();
      check("R8 no flag clear", clr_cnt, 0);
      @(negedge clk);
      in_stop = 1'b0;
    end

    run_recover(2, 1'b0, 1'b1, 1'b0, 2, "after_stop");              // R5, R10
    check("R10 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule